// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block derives the serial clock of a serial-peripheral master from the system clock. The division has two stages. A 13-bit prescaler produces one tick every `prescale + 1` system cycles. A 6-bit period counter advances on each tick and wraps after the value `period_end`. The output sits at its active level from count 0 through count `toggle_at`, and at its idle level from `toggle_at + 1` to the end of the period. The serial frequency is therefore fsys / (prescale + 1) / (period_end + 1). For a near-50% duty cycle, set `toggle_at` to floor((period_end + 1)/2 - 1).

Next to the clock level, the block gives a shift engine two single-cycle strobes. The launch strobe marks the start of every period, where the clock moves to its active level. The sample strobe marks the return to the idle level. A bypass input passes the system clock straight through. An idle-polarity input chooses the rest level. A clock-off input holds the pin at rest but leaves the strobes running. Change the mode inputs only while `enable` is low. All outputs are plain levels and pulses, with no handshake.

Top module: `spiclk_gen`

## Requirements
- R1: In divided mode, launch pulses repeat every (prescale+1)*(period_end+1) system cycles while `enable` stays high.
- R2: Each launch pulse comes in the same cycle as `sclk_o` moving to the active level (the inverse of `idle_high`). The clock then stays active for (toggle_at+1)*(prescale+1) cycles.
- R3: When toggle_at < period_end, `sample_o` pulses exactly once per period, in the first cycle in which `sclk_o` is back at the idle level. Otherwise it never pulses.
- R4: One cycle after the clock edge that first samples `enable` high, the block is at count 0: `sclk_o` is active and `launch_o` is 1.
- R5: One cycle after `enable` is sampled low, `sclk_o` is at the idle level and both strobes are 0. A later enable restarts from count 0.
- R6: The idle level equals `idle_high`: 0 rests low, 1 rests high.
- R7: With `clk_off` = 1, `sclk_o` holds the idle level, and `launch_o` and `sample_o` follow the same pattern as with `clk_off` = 0.
- R8: With `bypass` = 1 and the block running, `sclk_o` equals the system clock XOR `idle_high`, both strobes are 1 every cycle, and `prescale`, `toggle_at` and `period_end` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Transfer running; low holds the counters at zero |
| bypass | input | 1 | 1: serial clock is the system clock |
| idle_high | input | 1 | Rest level of the serial clock |
| clk_off | input | 1 | 1: serial clock held at the rest level |
| prescale | input | 13 | First-stage divide value minus one |
| toggle_at | input | 6 | Last count of the active half |
| period_end | input | 6 | Last count of the period |
| sclk_o | output | 1 | Serial clock level |
| launch_o | output | 1 | One-cycle strobe at the start of each period |
| sample_o | output | 1 | One-cycle strobe at the return to idle |

## Verification
A prescaler that stalls or overruns changes the spacing between launch pulses. That shows within one period as an early or late launch, and as a clock high phase of the wrong length. A period counter that wraps at the wrong value, or a compare that is off by one, moves the sample strobe or the falling edge of `sclk_o` within the first period after enable. A start flag that fails to clear leaves a strobe or an active level showing one cycle after enable drops, or makes the restart skip count 0.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;
  localparam int unsigned PRE_W = 13;
  localparam int unsigned CNT_W = 6;

  typedef struct packed {
    logic active;
    logic launch;
    logic sample;
  } phase_t;
endpackage

// File: rtl/spiclk_prescale.sv
module spiclk_prescale #(
  parameter int unsigned PRE_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] prescale,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt_q;
  logic             at_end;

  assign at_end = (pcnt_q == prescale);
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
    end else if (!run || at_end) begin
      pcnt_q <= '0;
    end else begin
      pcnt_q <= pcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/spiclk_period.sv
module spiclk_period
  import spiclk_pkg::*;
#(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             tick,
  input  logic [CNT_W-1:0] toggle_at,
  input  logic [CNT_W-1:0] period_end,
  output logic             started,
  output phase_t           phase
);
  localparam int unsigned EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] ccnt_q;
  logic [CNT_W-1:0] ccnt_nxt;
  logic [EXT_W-1:0] fall_pt;
  logic             started_q;
  phase_t           phase_q;

  assign ccnt_nxt = (ccnt_q == period_end) ? '0 : ccnt_q + 1'b1;
  assign fall_pt  = {1'b0, toggle_at} + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccnt_q    <= '0;
      started_q <= 1'b0;
      phase_q   <= '0;
    end else if (!enable) begin
      ccnt_q    <= '0;
      started_q <= 1'b0;
      phase_q   <= '0;
    end else if (!started_q) begin
      ccnt_q         <= '0;
      started_q      <= 1'b1;
      phase_q.active <= 1'b1;
      phase_q.launch <= 1'b1;
      phase_q.sample <= 1'b0;
    end else if (tick) begin
      ccnt_q         <= ccnt_nxt;
      phase_q.active <= (ccnt_nxt <= toggle_at);
      phase_q.launch <= (ccnt_nxt == '0);
      phase_q.sample <= ({1'b0, ccnt_nxt} == fall_pt);
    end else begin
      phase_q.launch <= 1'b0;
      phase_q.sample <= 1'b0;
    end
  end

  assign started = started_q;
  assign phase   = phase_q;
endmodule

// File: rtl/spiclk_outmux.sv
module spiclk_outmux
  import spiclk_pkg::*;
(
  input  logic   clk,
  input  logic   started,
  input  logic   bypass,
  input  logic   idle_high,
  input  logic   clk_off,
  input  phase_t phase,
  output logic   sclk_o,
  output logic   launch_o,
  output logic   sample_o
);
  always_comb begin
    if (bypass) begin
      sclk_o   = (started && !clk_off) ? (clk ^ idle_high) : idle_high;
      launch_o = started;
      sample_o = started;
    end else begin
      sclk_o   = (phase.active && !clk_off) ? !idle_high : idle_high;
      launch_o = phase.launch;
      sample_o = phase.sample;
    end
  end
endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
  import spiclk_pkg::*;
#(
  parameter int unsigned PW = PRE_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          bypass,
  input  logic          idle_high,
  input  logic          clk_off,
  input  logic [PW-1:0] prescale,
  input  logic [CW-1:0] toggle_at,
  input  logic [CW-1:0] period_end,
  output logic          sclk_o,
  output logic          launch_o,
  output logic          sample_o
);
  logic   started;
  logic   tick;
  phase_t phase;

  spiclk_prescale #(.PRE_W(PW)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (started && enable),
    .prescale (prescale),
    .tick     (tick)
  );

  spiclk_period #(.CNT_W(CW)) u_per (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tick       (tick),
    .toggle_at  (toggle_at),
    .period_end (period_end),
    .started    (started),
    .phase      (phase)
  );

  spiclk_outmux u_mux (
    .clk       (clk),
    .started   (started),
    .bypass    (bypass),
    .idle_high (idle_high),
    .clk_off   (clk_off),
    .phase     (phase),
    .sclk_o    (sclk_o),
    .launch_o  (launch_o),
    .sample_o  (sample_o)
  );
endmodule

// File: rtl/spiclk_gen_chk.sv
module spiclk_gen_chk #(
  parameter int unsigned PW = 13,
  parameter int unsigned CW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          bypass,
  input logic          idle_high,
  input logic          clk_off,
  input logic [PW-1:0] prescale,
  input logic [CW-1:0] toggle_at,
  input logic [CW-1:0] period_end,
  input logic          sclk_o,
  input logic          launch_o,
  input logic          sample_o
);
  logic [31:0] gap_q;
  logic        seen_q;
  logic [31:0] period_len;

  assign period_len = (32'(prescale) + 32'd1) * (32'(period_end) + 32'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= 32'd0;
      seen_q <= 1'b0;
    end else begin
      gap_q  <= launch_o ? 32'd1 : gap_q + 32'd1;
      seen_q <= (enable && !bypass) ? (seen_q | launch_o) : 1'b0;
    end
  end

  // R1: spacing of launch pulses in divided mode
  a_r1_period: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_o && !bypass && seen_q) |-> (gap_q == period_len));

  // R2: launch comes with the active level
  a_r2_launch_active: assert property (@(posedge clk) disable iff (!rst_n)
    (launch_o && !bypass && !clk_off) |-> (sclk_o != idle_high));

  // R3: sample comes with the return to idle
  a_r3_sample_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_o && !bypass) |-> (sclk_o == idle_high));

  // R5: quiet one cycle after enable drops
  a_r5_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (sclk_o == idle_high && !launch_o && !sample_o));

  // R8: strobes every cycle in bypass
  a_r8_bypass_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && enable && $past(enable) && $past(bypass)) |-> (launch_o && sample_o));
endmodule

bind spiclk_gen spiclk_gen_chk #(.PW(PW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .bypass     (bypass),
  .idle_high  (idle_high),
  .clk_off    (clk_off),
  .prescale   (prescale),
  .toggle_at  (toggle_at),
  .period_end (period_end),
  .sclk_o     (sclk_o),
  .launch_o   (launch_o),
  .sample_o   (sample_o)
);

// File: tb/sim_spiclk_gen.sv
module sim_spiclk_gen;
  typedef struct {
    logic  lvl;
    logic  lau;
    logic  smp;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        bypass = 1'b0;
  logic        idle_high = 1'b0;
  logic        clk_off = 1'b0;
  logic [12:0] prescale = '0;
  logic [5:0]  toggle_at = '0;
  logic [5:0]  period_end = '0;
  logic        sclk_o, launch_o, sample_o;

  int   n_checks = 0;
  int   n_fails = 0;
  exp_t q[$];

  always #2 clk = ~clk;

  spiclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bypass(bypass),
    .idle_high(idle_high), .clk_off(clk_off), .prescale(prescale),
    .toggle_at(toggle_at), .period_end(period_end),
    .sclk_o(sclk_o), .launch_o(launch_o), .sample_o(sample_o)
  );

  // monitor: pops one expected item per cycle, compares just after the edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_checks++;
      if (sclk_o !== e.lvl || launch_o !== e.lau || sample_o !== e.smp) begin
        n_fails++;
        $display("FAIL %s: got sclk=%b launch=%b sample=%b, expected sclk=%b launch=%b sample=%b",
                 e.req, sclk_o, launch_o, sample_o, e.lvl, e.lau, e.smp);
      end
    end
  end

  function automatic exp_t model(int i, string req);
    exp_t e;
    int per, p, k;
    e.req = req;
    if (bypass) begin
      e.lvl = clk_off ? idle_high : !idle_high;
      e.lau = 1'b1;
      e.smp = 1'b1;
    end else begin
      per   = (int'(prescale) + 1) * (int'(period_end) + 1);
      p     = i % per;
      k     = p / (int'(prescale) + 1);
      e.lvl = ((k <= int'(toggle_at)) && !clk_off) ? !idle_high : idle_high;
      e.lau = (p == 0);
      e.smp = (toggle_at < period_end) &&
              (p == (int'(toggle_at) + 1) * (int'(prescale) + 1));
    end
    return e;
  endfunction

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
  endtask

  // driver: program, push expectations, run, stop and expect the quiet state
  task automatic run_case(input logic [12:0] pre, input logic [5:0] hi,
                          input logic [5:0] lo, input logic idl, input logic off,
                          input logic byp, input int cycles, input string req);
    @(negedge clk);
    prescale = pre; toggle_at = hi; period_end = lo;
    idle_high = idl; clk_off = off; bypass = byp;
    @(negedge clk);
    for (int i = 0; i < cycles; i++) q.push_back(model(i, req));
    enable = 1'b1;
    drain();
    enable = 1'b0;
    for (int i = 0; i < 2; i++) begin
      exp_t e;
      e.lvl = idl; e.lau = 1'b0; e.smp = 1'b0; e.req = "R5 quiet after stop";
      q.push_back(e);
    end
    drain();
  endtask

  initial begin
    #(200000 * 4);
    n_fails++;
    $display("FAIL watchdog: got hang, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_checks++;
    if (sclk_o !== 1'b0 || launch_o !== 1'b0 || sample_o !== 1'b0) begin
      n_fails++;
      $display("FAIL R5 reset: got %b%b%b, expected 000", sclk_o, launch_o, sample_o);
    end
    // R1 R2 R3 R4: no prescale, four-count period
    run_case(13'd0, 6'd1, 6'd3, 1'b0, 1'b0, 1'b0, 12, "R1/R4 pre0 L3 H1");
    // R1 R2 R3: prescale by 3, uneven duty
    run_case(13'd2, 6'd2, 6'd5, 1'b0, 1'b0, 1'b0, 40, "R2/R3 pre2 L5 H2");
    // R6: rest high
    run_case(13'd1, 6'd1, 6'd4, 1'b1, 1'b0, 1'b0, 25, "R6 idle high");
    // R3: toggle point not below period end -> no sample
    run_case(13'd0, 6'd3, 6'd3, 1'b0, 1'b0, 1'b0, 10, "R3 no sample");
    // R7: clock off, strobes continue
    run_case(13'd0, 6'd1, 6'd3, 1'b0, 1'b1, 1'b0, 12, "R7 clock off");
    // R8: bypass with arbitrary divider fields
    run_case(13'd77, 6'd9, 6'd20, 1'b0, 1'b0, 1'b1, 8, "R8 bypass");
    run_case(13'd5, 6'd0, 6'd1, 1'b1, 1'b0, 1'b1, 6, "R8 bypass idle high");
    // R5: restart from count 0 after a stop
    run_case(13'd1, 6'd0, 6'd2, 1'b0, 1'b0, 1'b0, 9, "R5 restart");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule